// File: doc/BRIEF.md
# Multi-Mode Interprocessor Mailbox Controller

This block carries messages one way, from a sending processor to a receiving processor on the same chip. Two-way traffic uses two instances, one in each direction. Each side has its own simple register port: a write strobe, a read strobe, a 16-bit byte address (a 64 KiB window), and a 32-bit data word. Read data is registered and appears on the cycle after the read strobe.

The mailbox has eleven logical channels. Channels 0 to 7 are fast channels. Each holds one word and flags it as pending until the receiver reads it. Channel 8 is a doorbell that carries no data. Channel 9 is a 32-entry word FIFO. Channel 10 is a 32-word message block: the sender fills the words and rings it, and the receiver answers with an acknowledgment that the sender clears.

Each side has one active-high level interrupt. The receiver interrupt is the OR, over all channels, of the channel's pending bit ANDed with its enable bit. The sender interrupt reports the message-block acknowledgment.

Top module: `ipc_mailbox`

## Requirements
- R1: After reset, every pending bit, enable bit, overrun bit, FIFO error bit and acknowledgment is 0. Both interrupts are low and both read-data outputs are 0. The FIFO status reads 0x1 (empty).
- R2: A sender write to offset 0x0000+4*i (i = 0..7) stores the word in fast channel i and sets bit i of the receiver pending register at offset 0x0300. A receiver read of the same offset returns the word and clears bit i. The word stays readable after that.
- R3: A sender write to a fast channel whose pending bit is already set replaces the word and sets bit i of the sticky overrun register at receiver offset 0x0308. The receiver clears an overrun bit by writing 1 to that bit.
- R4: A sender write of any value to offset 0x0020 sets pending bit 8 and stores no data. A receiver read of 0x0020 returns 0. A receiver write to 0x0300 with bit 8 set clears pending bit 8.
- R5: Words the sender writes to offset 0x0040 are returned in the same order by receiver reads of 0x0040. The FIFO holds up to 32 words. Pending bit 9 is 1 exactly when the FIFO holds at least one word.
- R6: Receiver offset 0x0044 reports FIFO status: bit 0 empty, bit 1 full, bit 2 overflow, bit 3 underflow, bits [13:8] fill level. Writing 1 to bit 2 or bit 3 clears that flag.
- R7: A sender write to 0x0040 while the FIFO is full is dropped and sets the overflow flag. The stored words and the fill level do not change.
- R8: A receiver read of 0x0040 while the FIFO is empty returns 0, sets the underflow flag and leaves the level at 0.
- R9: The sender writes message words at offset 0x0100+4*k (k = 0..31), and the receiver reads them at the same offsets. A sender write to 0x0200 sets pending bit 10.
- R10: A receiver write to 0x0200 clears pending bit 10 and sets the acknowledgment, which is bit 0 of sender offset 0x0300. The acknowledgment stays set until the sender writes 1 to that bit.
- R11: Receiver offset 0x0304 bits [10:0] are per-channel enables. r_irq is high exactly when some channel is both pending and enabled. It follows the pending state with no added delay.
- R12: Bit 0 of sender offset 0x0304 enables the sender interrupt. s_irq is high exactly when the acknowledgment is set and that enable is 1.
- R13: s_rdata and r_rdata take a new value on the clock edge where the read strobe is sampled, and hold it otherwise. Unmapped offsets read as 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| s_wr | input | 1 | Sender write strobe |
| s_rd | input | 1 | Sender read strobe |
| s_addr | input | 16 | Sender byte address |
| s_wdata | input | 32 | Sender write data |
| s_rdata | output | 32 | Sender read data, registered |
| r_wr | input | 1 | Receiver write strobe |
| r_rd | input | 1 | Receiver read strobe |
| r_addr | input | 16 | Receiver byte address |
| r_wdata | input | 32 | Receiver write data |
| r_rdata | output | 32 | Receiver read data, registered |
| s_irq | output | 1 | Sender interrupt, level, active high |
| r_irq | output | 1 | Receiver interrupt, level, active high |

## Verification
The assertions assume each side issues at most one strobe per cycle and uses word-aligned addresses. The ack-hold and overrun properties assume the sender and receiver do not act on the same channel in the same cycle. The bench keeps within these limits because it drives one access at a time through tasks, always at word-aligned offsets. Its random addresses are drawn only from the mapped channel offsets. Directed sequences push the FIFO past full and pop it past empty, write a fast channel twice before reading it, and run the message ring and acknowledge handshake with the interrupt enables on.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
   // register offsets (bytes)
   localparam int unsigned OFF_FAST      = 'h0000;
   localparam int unsigned OFF_DB        = 'h0020;
   localparam int unsigned OFF_FIFO_DATA = 'h0040;
   localparam int unsigned OFF_FIFO_STAT = 'h0044;
   localparam int unsigned OFF_MSG       = 'h0100;
   localparam int unsigned OFF_MSG_CTL   = 'h0200;
   localparam int unsigned OFF_STAT      = 'h0300;
   localparam int unsigned OFF_IEN       = 'h0304;
   localparam int unsigned OFF_OVR       = 'h0308;
   // fifo status fields
   localparam int unsigned FST_EMPTY = 0;
   localparam int unsigned FST_FULL  = 1;
   localparam int unsigned FST_OVF   = 2;
   localparam int unsigned FST_UDF   = 3;
   localparam int unsigned FST_LVL   = 8;
   localparam int unsigned MAX_FAST  = 8;
endpackage

// File: rtl/mbx_fast_chan.sv
module mbx_fast_chan #(
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wdata,
   input  logic              rd_en,
   input  logic              ovr_clr,
   output logic [DATA_W-1:0] data,
   output logic              pending,
   output logic              overrun
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data    <= '0;
         pending <= 1'b0;
         overrun <= 1'b0;
      end else begin
         if (wr_en) data <= wdata;
         if (wr_en)      pending <= 1'b1;
         else if (rd_en) pending <= 1'b0;
         if (wr_en && pending && !rd_en) overrun <= 1'b1;
         else if (ovr_clr)               overrun <= 1'b0;
      end
   end
endmodule

// File: rtl/mbx_fifo.sv
module mbx_fifo #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned DEPTH  = 32,
   localparam int unsigned AW    = $clog2(DEPTH),
   localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [DATA_W-1:0] push_data,
   input  logic              pop,
   input  logic              ovf_clr,
   input  logic              udf_clr,
   output logic [DATA_W-1:0] head,
   output logic              empty,
   output logic              full,
   output logic [LVL_W-1:0]  level,
   output logic              ovf,
   output logic              udf
);
   if (DEPTH < 2 || (1 << AW) != DEPTH) begin : g_bad_depth
      $error("mbx_fifo: DEPTH must be a power of two >= 2");
   end

   logic [DATA_W-1:0] mem [DEPTH];
   logic [AW-1:0]     wr_ptr, rd_ptr;
   logic              push_ok, pop_ok;

   assign empty   = (level == '0);
   assign full    = (level == LVL_W'(DEPTH));
   assign push_ok = push && !full;
   assign pop_ok  = pop && !empty;
   assign head    = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (push_ok) mem[wr_ptr] <= push_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         level  <= '0;
         ovf    <= 1'b0;
         udf    <= 1'b0;
      end else begin
         if (push_ok) wr_ptr <= wr_ptr + 1'b1;
         if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
         case ({push_ok, pop_ok})
            2'b10:   level <= level + 1'b1;
            2'b01:   level <= level - 1'b1;
            default: level <= level;
         endcase
         if (push && full)       ovf <= 1'b1;
         else if (ovf_clr)       ovf <= 1'b0;
         if (pop && empty)       udf <= 1'b1;
         else if (udf_clr)       udf <= 1'b0;
      end
   end
endmodule

// File: rtl/mbx_msg_block.sv
module mbx_msg_block #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned WORDS  = 32,
   localparam int unsigned IW    = $clog2(WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IW-1:0]     wr_idx,
   input  logic [DATA_W-1:0] wdata,
   input  logic [IW-1:0]     rd_idx,
   output logic [DATA_W-1:0] rd_data,
   input  logic              send,
   input  logic              ack,
   input  logic              ack_clr,
   output logic              bell,
   output logic              ack_flag
);
   logic [DATA_W-1:0] words [WORDS];

   for (genvar k = 0; k < WORDS; k++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                          words[k] <= '0;
         else if (wr_en && wr_idx == IW'(k))  words[k] <= wdata;
      end
   end

   assign rd_data = words[rd_idx];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bell     <= 1'b0;
         ack_flag <= 1'b0;
      end else begin
         if (send)      bell <= 1'b1;
         else if (ack)  bell <= 1'b0;
         if (ack)          ack_flag <= 1'b1;
         else if (ack_clr) ack_flag <= 1'b0;
      end
   end
endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox
   import mbx_pkg::*;
#(
   parameter int unsigned ADDR_W     = 16,
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned NUM_FAST   = 8,
   parameter int unsigned FIFO_DEPTH = 32,
   parameter int unsigned MSG_WORDS  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              s_wr,
   input  logic              s_rd,
   input  logic [ADDR_W-1:0] s_addr,
   input  logic [DATA_W-1:0] s_wdata,
   output logic [DATA_W-1:0] s_rdata,
   input  logic              r_wr,
   input  logic              r_rd,
   input  logic [ADDR_W-1:0] r_addr,
   input  logic [DATA_W-1:0] r_wdata,
   output logic [DATA_W-1:0] r_rdata,
   output logic              s_irq,
   output logic              r_irq
);
   localparam int unsigned NUM_CH  = NUM_FAST + 3;
   localparam int unsigned CH_DB   = NUM_FAST;
   localparam int unsigned CH_FIFO = NUM_FAST + 1;
   localparam int unsigned CH_MSG  = NUM_FAST + 2;
   localparam int unsigned LVL_W   = $clog2(FIFO_DEPTH + 1);
   localparam int unsigned MSG_IW  = $clog2(MSG_WORDS);

   localparam logic [ADDR_W-1:0] A_DB   = ADDR_W'(OFF_DB);
   localparam logic [ADDR_W-1:0] A_FDAT = ADDR_W'(OFF_FIFO_DATA);
   localparam logic [ADDR_W-1:0] A_FST  = ADDR_W'(OFF_FIFO_STAT);
   localparam logic [ADDR_W-1:0] A_MCTL = ADDR_W'(OFF_MSG_CTL);
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFF_STAT);
   localparam logic [ADDR_W-1:0] A_IEN  = ADDR_W'(OFF_IEN);
   localparam logic [ADDR_W-1:0] A_OVR  = ADDR_W'(OFF_OVR);

   // elaboration-time parameter checks
   if (NUM_FAST < 1 || NUM_FAST > MAX_FAST) begin : g_chk_fast
      $error("ipc_mailbox: NUM_FAST out of range 1..8");
   end
   if (ADDR_W < 10 || ADDR_W > 32) begin : g_chk_addr
      $error("ipc_mailbox: ADDR_W must be 10..32");
   end
   if (DATA_W < NUM_CH || DATA_W < FST_LVL + LVL_W) begin : g_chk_data
      $error("ipc_mailbox: DATA_W too narrow for status fields");
   end
   if (MSG_WORDS < 2 || MSG_WORDS > 64 || (1 << MSG_IW) != MSG_WORDS) begin : g_chk_msg
      $error("ipc_mailbox: MSG_WORDS must be a power of two 2..64");
   end

   // ---------------- address decode ----------------
   function automatic logic fast_hit(input logic [ADDR_W-1:0] a);
      return (a[ADDR_W-1:5] == '0) && (a[1:0] == 2'b00) && (32'(a[4:2]) < NUM_FAST);
   endfunction
   function automatic logic msg_hit(input logic [ADDR_W-1:0] a);
      return (a[ADDR_W-1:8] == (ADDR_W-8)'(OFF_MSG >> 8)) && (a[1:0] == 2'b00) &&
             (32'(a[7:2]) < MSG_WORDS);
   endfunction

   logic s_fast_wr, r_fast_rd, s_msg_wr, r_msg_sel;
   assign s_fast_wr = s_wr && fast_hit(s_addr);
   assign r_fast_rd = r_rd && fast_hit(r_addr);
   assign s_msg_wr  = s_wr && msg_hit(s_addr);
   assign r_msg_sel = msg_hit(r_addr);

   // ---------------- fast channels ----------------
   logic [DATA_W-1:0]   fast_data [MAX_FAST];
   logic [NUM_FAST-1:0] fast_pend;
   logic [NUM_FAST-1:0] fast_ovr;

   for (genvar i = 0; i < MAX_FAST; i++) begin : g_fast
      if (i < NUM_FAST) begin : g_on
         mbx_fast_chan #(.DATA_W(DATA_W)) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (s_fast_wr && s_addr[4:2] == 3'(i)),
            .wdata   (s_wdata),
            .rd_en   (r_fast_rd && r_addr[4:2] == 3'(i)),
            .ovr_clr (r_wr && r_addr == A_OVR && r_wdata[i]),
            .data    (fast_data[i]),
            .pending (fast_pend[i]),
            .overrun (fast_ovr[i])
         );
      end else begin : g_off
         assign fast_data[i] = '0;
      end
   end

   // ---------------- doorbell ----------------
   logic db_pend;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                      db_pend <= 1'b0;
      else if (s_wr && s_addr == A_DB)                 db_pend <= 1'b1;
      else if (r_wr && r_addr == A_STAT && r_wdata[CH_DB]) db_pend <= 1'b0;
   end

   // ---------------- fifo channel ----------------
   logic [DATA_W-1:0] fifo_head;
   logic              fifo_empty, fifo_full, fifo_ovf, fifo_udf;
   logic [LVL_W-1:0]  fifo_level;

   mbx_fifo #(.DATA_W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (s_wr && s_addr == A_FDAT),
      .push_data (s_wdata),
      .pop       (r_rd && r_addr == A_FDAT),
      .ovf_clr   (r_wr && r_addr == A_FST && r_wdata[FST_OVF]),
      .udf_clr   (r_wr && r_addr == A_FST && r_wdata[FST_UDF]),
      .head      (fifo_head),
      .empty     (fifo_empty),
      .full      (fifo_full),
      .level     (fifo_level),
      .ovf       (fifo_ovf),
      .udf       (fifo_udf)
   );

   // ---------------- message block ----------------
   logic [DATA_W-1:0] msg_rd;
   logic              msg_bell, msg_ack;

   mbx_msg_block #(.DATA_W(DATA_W), .WORDS(MSG_WORDS)) u_msg (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (s_msg_wr),
      .wr_idx   (s_addr[2 +: MSG_IW]),
      .wdata    (s_wdata),
      .rd_idx   (r_addr[2 +: MSG_IW]),
      .rd_data  (msg_rd),
      .send     (s_wr && s_addr == A_MCTL),
      .ack      (r_wr && r_addr == A_MCTL),
      .ack_clr  (s_wr && s_addr == A_STAT && s_wdata[0]),
      .bell     (msg_bell),
      .ack_flag (msg_ack)
   );

   // ---------------- enables and interrupts ----------------
   logic [NUM_CH-1:0] pend_vec, r_ien;
   logic              s_ien;

   assign pend_vec = {msg_bell, !fifo_empty, db_pend, fast_pend};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         r_ien <= '0;
         s_ien <= 1'b0;
      end else begin
         if (r_wr && r_addr == A_IEN) r_ien <= r_wdata[NUM_CH-1:0];
         if (s_wr && s_addr == A_IEN) s_ien <= s_wdata[0];
      end
   end

   assign r_irq = |(pend_vec & r_ien);
   assign s_irq = msg_ack & s_ien;

   // ---------------- read paths ----------------
   logic [DATA_W-1:0] fifo_stat, r_rd_val, s_rd_val;

   always_comb begin
      fifo_stat                    = '0;
      fifo_stat[FST_EMPTY]         = fifo_empty;
      fifo_stat[FST_FULL]          = fifo_full;
      fifo_stat[FST_OVF]           = fifo_ovf;
      fifo_stat[FST_UDF]           = fifo_udf;
      fifo_stat[FST_LVL +: LVL_W]  = fifo_level;
   end

   always_comb begin
      r_rd_val = '0;
      if (fast_hit(r_addr))     r_rd_val = fast_data[r_addr[4:2]];
      else if (r_msg_sel)       r_rd_val = msg_rd;
      else if (r_addr == A_FDAT) r_rd_val = fifo_empty ? '0 : fifo_head;
      else if (r_addr == A_FST)  r_rd_val = fifo_stat;
      else if (r_addr == A_STAT) r_rd_val = DATA_W'(pend_vec);
      else if (r_addr == A_IEN)  r_rd_val = DATA_W'(r_ien);
      else if (r_addr == A_OVR)  r_rd_val = DATA_W'(fast_ovr);
   end

   always_comb begin
      s_rd_val = '0;
      if (s_addr == A_STAT) begin
         s_rd_val[0]                = msg_ack;
         s_rd_val[1]                = fifo_full;
         s_rd_val[FST_LVL +: LVL_W] = fifo_level;
      end else if (s_addr == A_IEN) begin
         s_rd_val[0] = s_ien;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         r_rdata <= '0;
         s_rdata <= '0;
      end else begin
         if (r_rd) r_rdata <= r_rd_val;
         if (s_rd) s_rdata <= s_rd_val;
      end
   end

   logic unused_wdata_bits;
   assign unused_wdata_bits = ^{r_wdata, s_wdata[DATA_W-1:1]};
endmodule

// File: rtl/mbx_checker.sv
module mbx_checker
   import mbx_pkg::*;
#(
   parameter int unsigned ADDR_W     = 16,
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned NUM_FAST   = 8,
   parameter int unsigned NUM_CH     = 11,
   parameter int unsigned FIFO_DEPTH = 32,
   parameter int unsigned LVL_W      = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              s_wr,
   input logic [ADDR_W-1:0] s_addr,
   input logic [DATA_W-1:0] s_wdata,
   input logic              r_rd,
   input logic [ADDR_W-1:0] r_addr,
   input logic [DATA_W-1:0] r_rdata,
   input logic [NUM_CH-1:0] pend,
   input logic [NUM_CH-1:0] ien,
   input logic [NUM_FAST-1:0] ovr,
   input logic              fifo_empty,
   input logic              fifo_full,
   input logic [LVL_W-1:0]  fifo_level,
   input logic              ack,
   input logic              s_irq,
   input logic              r_irq
);
   assert_fast_pending_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (s_wr && s_addr == '0) |=> pend[0]);

   assert_overrun_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (s_wr && s_addr == '0 && pend[0] && !(r_rd && r_addr == '0)) |=> ovr[0]);

   assert_fifo_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
      32'(fifo_level) <= FIFO_DEPTH);

   assert_fifo_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(fifo_empty && fifo_full));

   assert_underflow_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (r_rd && r_addr == ADDR_W'(OFF_FIFO_DATA) && fifo_empty) |=> (r_rdata == '0));

   assert_ack_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && !(s_wr && s_addr == ADDR_W'(OFF_STAT) && s_wdata[0])) |=> ack);

   assert_doorbell_irq_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (s_wr && s_addr == ADDR_W'(OFF_DB) && ien[NUM_FAST]) |=> r_irq);

   assert_sender_irq_R12: assert property (@(posedge clk) disable iff (!rst_n)
      s_irq |-> ack);
endmodule

bind ipc_mailbox mbx_checker #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_FAST(NUM_FAST),
   .NUM_CH(NUM_CH), .FIFO_DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .s_wr(s_wr), .s_addr(s_addr), .s_wdata(s_wdata),
   .r_rd(r_rd), .r_addr(r_addr), .r_rdata(r_rdata), .pend(pend_vec), .ien(r_ien),
   .ovr(fast_ovr), .fifo_empty(fifo_empty), .fifo_full(fifo_full),
   .fifo_level(fifo_level), .ack(msg_ack), .s_irq(s_irq), .r_irq(r_irq)
);

// File: tb/ipc_mailbox_tb.sv
module ipc_mailbox_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        s_wr = 0, s_rd = 0, r_wr = 0, r_rd = 0;
   logic [15:0] s_addr = '0, r_addr = '0;
   logic [31:0] s_wdata = '0, r_wdata = '0;
   logic [31:0] s_rdata, r_rdata;
   logic        s_irq, r_irq;

   always #4 clk = ~clk;   // 125 MHz

   ipc_mailbox u_dut (
      .clk(clk), .rst_n(rst_n),
      .s_wr(s_wr), .s_rd(s_rd), .s_addr(s_addr), .s_wdata(s_wdata), .s_rdata(s_rdata),
      .r_wr(r_wr), .r_rd(r_rd), .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata),
      .s_irq(s_irq), .r_irq(r_irq)
   );

   int checks = 0, failures = 0;
   bit done = 0;

   // ---------- reference model ----------
   logic [31:0] m_fast [8];
   logic [7:0]  m_fpend = '0, m_ovr = '0;
   logic        m_db = 0, m_bell = 0, m_ack = 0, m_sien = 0;
   logic        m_ovf = 0, m_udf = 0;
   logic [10:0] m_ien = '0;
   logic [31:0] m_msg [32];
   logic [31:0] m_q [$];

   function automatic logic [10:0] exp_pend();
      return {m_bell, m_q.size() != 0, m_db, m_fpend};
   endfunction
   function automatic logic [31:0] exp_fstat();
      logic [31:0] v = '0;
      v[0] = (m_q.size() == 0);
      v[1] = (m_q.size() == 32);
      v[2] = m_ovf;
      v[3] = m_udf;
      v[13:8] = 6'(m_q.size());
      return v;
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // ---------- bus tasks (start and end at negedge) ----------
   task automatic s_write(input logic [15:0] a, input logic [31:0] d);
      s_wr = 1; s_addr = a; s_wdata = d;
      @(posedge clk); @(negedge clk);
      s_wr = 0;
   endtask
   task automatic r_write(input logic [15:0] a, input logic [31:0] d);
      r_wr = 1; r_addr = a; r_wdata = d;
      @(posedge clk); @(negedge clk);
      r_wr = 0;
   endtask
   task automatic r_read(input logic [15:0] a, output logic [31:0] d);
      r_rd = 1; r_addr = a;
      @(posedge clk); @(negedge clk);
      r_rd = 0; d = r_rdata;
   endtask
   task automatic s_read(input logic [15:0] a, output logic [31:0] d);
      s_rd = 1; s_addr = a;
      @(posedge clk); @(negedge clk);
      s_rd = 0; d = s_rdata;
   endtask

   // model-updating operations
   task automatic do_fast_wr(input int i, input logic [31:0] d);
      s_write(16'(4*i), d);
      if (m_fpend[i]) m_ovr[i] = 1'b1;
      m_fast[i] = d; m_fpend[i] = 1'b1;
   endtask
   task automatic do_fast_rd(input int i);
      logic [31:0] d;
      r_read(16'(4*i), d);
      check("R2 fast read", d, m_fast[i]);
      m_fpend[i] = 1'b0;
   endtask
   task automatic do_push(input logic [31:0] d);
      s_write(16'h0040, d);
      if (m_q.size() == 32) m_ovf = 1'b1; else m_q.push_back(d);
   endtask
   task automatic do_pop();
      logic [31:0] d, e;
      r_read(16'h0040, d);
      if (m_q.size() == 0) begin e = '0; m_udf = 1'b1; end
      else e = m_q.pop_front();
      check("R5/R8 fifo pop", d, e);
   endtask
   task automatic check_irqs(input string tag);
      check({tag, " R11 r_irq"}, 32'(r_irq), 32'(|(exp_pend() & m_ien)));
      check({tag, " R12 s_irq"}, 32'(s_irq), 32'(m_ack & m_sien));
   endtask

   // ---------- watchdog ----------
   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   // ---------- main ----------
   initial begin
      logic [31:0] d;
      for (int i = 0; i < 8; i++) m_fast[i] = '0;
      for (int k = 0; k < 32; k++) m_msg[k] = '0;
      void'($urandom(32'd7021));
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);

      // R1 reset state
      check("R1 r_rdata", r_rdata, 0);
      check("R1 s_rdata", s_rdata, 0);
      check("R1 r_irq", 32'(r_irq), 0);
      check("R1 s_irq", 32'(s_irq), 0);
      r_read(16'h0300, d); check("R1 pending", d, 0);
      r_read(16'h0044, d); check("R1 fifo status", d, 32'h1);
      r_read(16'h0308, d); check("R1 overrun", d, 0);
      s_read(16'h0300, d); check("R1 sender status", d, 0);

      // R2 / R3 fast channel and overrun
      do_fast_wr(3, 32'hA5A5_0003);
      r_read(16'h0300, d); check("R2 pending bit3", d, 32'h8);
      do_fast_wr(3, 32'h1234_5678);
      r_read(16'h0308, d); check("R3 overrun bit3", d, 32'h8);
      do_fast_rd(3);
      r_read(16'h0300, d); check("R2 pending cleared", d, 0);
      r_read(16'h000C, d); check("R2 word kept", d, 32'h1234_5678);
      r_write(16'h0308, 32'h8); m_ovr = '0;
      r_read(16'h0308, d); check("R3 overrun W1C", d, 0);

      // R4 doorbell
      s_write(16'h0020, 32'hFFFF_FFFF); m_db = 1;
      r_read(16'h0020, d); check("R4 doorbell reads zero", d, 0);
      r_read(16'h0300, d); check("R4 pending bit8", d, 32'h100);
      r_write(16'h0304, 32'h100); m_ien = 11'h100;
      check_irqs("R4");
      r_write(16'h0300, 32'h100); m_db = 0;
      check_irqs("R4 cleared");
      r_read(16'h0300, d); check("R4 pending cleared", d, 0);

      // R5-R8 fifo fill, overflow, drain, underflow
      for (int k = 0; k < 32; k++) do_push(32'hF000_0000 + 32'(k));
      r_read(16'h0044, d); check("R6 full status", d, exp_fstat());
      check("R6 full value", d, 32'h2002);
      do_push(32'hDEAD_BEEF);
      r_read(16'h0044, d); check("R7 overflow status", d, 32'h2006);
      r_read(16'h0300, d); check("R5 pending bit9", d, 32'h200);
      for (int k = 0; k < 32; k++) do_pop();
      do_pop();
      r_read(16'h0044, d); check("R8 underflow status", d, 32'h000D);
      r_write(16'h0044, 32'hC); m_ovf = 0; m_udf = 0;
      r_read(16'h0044, d); check("R6 W1C flags", d, 32'h1);

      // R9/R10/R12 message block
      for (int k = 0; k < 32; k++) begin
         m_msg[k] = $urandom;
         s_write(16'h0100 + 16'(4*k), m_msg[k]);
      end
      s_write(16'h0304, 1); m_sien = 1;
      s_write(16'h0200, 0); m_bell = 1;
      r_read(16'h0300, d); check("R9 pending bit10", d, 32'h400);
      r_read(16'h0100, d); check("R9 word0", d, m_msg[0]);
      r_read(16'h017C, d); check("R9 word31", d, m_msg[31]);
      check_irqs("R9");
      r_write(16'h0200, 0); m_bell = 0; m_ack = 1;
      s_read(16'h0300, d); check("R10 ack set", d, 32'h1);
      check_irqs("R10 ack");
      s_write(16'h0300, 0);
      s_read(16'h0300, d); check("R10 ack holds on write 0", d, 32'h1);
      s_write(16'h0300, 1); m_ack = 0;
      check_irqs("R10 ack cleared");

      // R13 unmapped and hold
      r_read(16'h0400, d); check("R13 unmapped read", d, 0);
      s_write(16'h0500, 32'hFFFF_FFFF);
      r_read(16'h0300, d); check("R13 unmapped write ignored", d, 0);
      s_read(16'h0304, d);
      @(negedge clk); check("R13 rdata hold", s_rdata, 32'h1);

      // randomized traffic
      for (int n = 0; n < 4000; n++) begin
         int op = int'($urandom_range(0, 9));
         int ch = int'($urandom_range(0, 7));
         case (op)
            0, 1: do_fast_wr(ch, $urandom);
            2: do_fast_rd(ch);
            3: begin s_write(16'h0020, $urandom); m_db = 1; end
            4: do_push($urandom);
            5: do_pop();
            6: begin
               m_ien = 11'($urandom);
               r_write(16'h0304, 32'(m_ien));
            end
            7: begin
               int k = int'($urandom_range(0, 31));
               m_msg[k] = $urandom;
               s_write(16'h0100 + 16'(4*k), m_msg[k]);
               r_read(16'h0100 + 16'(4*k), d); check("R9 msg word", d, m_msg[k]);
            end
            8: begin
               case ($urandom_range(0, 3))
                  0: begin s_write(16'h0200, 0); m_bell = 1; end
                  1: begin r_write(16'h0200, 0); m_bell = 0; m_ack = 1; end
                  2: begin s_write(16'h0300, 1); m_ack = 0; end
                  default: begin r_write(16'h0300, 32'h100); m_db = 0; end
               endcase
            end
            default: begin
               r_read(16'h0300, d); check("R11 pending vector", d, 32'(exp_pend()));
               r_read(16'h0044, d); check("R6 fifo status", d, exp_fstat());
               r_read(16'h0308, d); check("R3 overrun vector", d, 32'(m_ovr));
            end
         endcase
         check_irqs("rand");
      end

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule